// File: doc/BRIEF.md
# Request Packet Formatter with Payload Alignment Modes

The block turns a four-Dword request descriptor and a separate stream of payload Dwords into AXI4-Stream request packets. Each packet begins with the descriptor in the lowest lanes. The payload follows in one of two layouts. In packed mode the payload continues directly after the descriptor. In aligned mode the payload starts on the beat after the descriptor, at a lane taken from the target address. Any filler Dwords in between are counted as valid in `m_tkeep`.

Payload beats go into an internal Dword buffer. A packet is started only once its whole payload is buffered. This is how the block keeps `m_tvalid` high for the full packet even when the payload source stalls. The byte enables and the starting-lane field come out on side-band ports during the first beat of each packet. Sink backpressure freezes every output. The data width is set by `DATA_W` to 64, 128 or 256 bits.

Top module: `reqpkt_fmt`

## Requirements
- R1: After reset, `m_tvalid` is 0, and `d_ready` and `p_ready` are 1.
- R2: Output Dword positions are counted across beats, with position = beat × LANES + lane. Positions 0..3 carry descriptor Dwords 0..3, where Dword i is `d_hdr[32i+31:32i]`.
- R3: In packed mode (`d_mode`=0), payload Dword k sits at position 4+k, with no filler.
- R4: In aligned mode (`d_mode`=1), payload Dword 0 sits in the beat after the last descriptor beat, at lane `d_aoff` mod LANES. The filler positions before it carry zero data and have keep set.
- R5: On the first beat, `m_fbe` and `m_lbe` show the descriptor's byte enables. On that beat `m_lane` shows the starting lane in aligned mode and 0 in packed mode. On every other beat all three fields are 0.
- R6: `m_tlast` is 1 only on the final beat. `m_tkeep` is all ones on every other beat. On the final beat `m_tkeep` is set contiguously from lane 0 up to the last payload Dword.
- R7: While `m_tvalid` is 1 and `m_tready` is 0, all outputs hold their values into the next cycle.
- R8: `m_tvalid` stays 0 until all `d_len` payload Dwords of the packet are buffered. Once it rises, it does not fall before the final beat handshakes.
- R9: `p_ready` is 1 when the buffer has room for a full beat. An accepted beat stores its lowest `p_ndw` Dwords in lane order, ahead of the Dwords of later beats.
- R10: `d_ready` is 1 only while no packet is pending, so it is never 1 together with `m_tvalid`. The next descriptor is taken after the final beat of the previous packet has handshaked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| d_valid | input | 1 | Descriptor offered |
| d_ready | output | 1 | Descriptor taken |
| d_hdr | input | 128 | Four descriptor Dwords |
| d_mode | input | 1 | 0 packed, 1 aligned |
| d_aoff | input | 3 | Target address bits [4:2] |
| d_len | input | clog2(BUF_DW+1) | Payload length in Dwords, 1..BUF_DW |
| d_fbe | input | 4 | First-Dword byte enables |
| d_lbe | input | 4 | Last-Dword byte enables |
| p_valid | input | 1 | Payload beat offered |
| p_ready | output | 1 | Payload beat taken |
| p_data | input | DATA_W | Payload Dwords, lane 0 first |
| p_ndw | input | clog2(LANES+1) | Valid Dwords in the payload beat |
| m_tvalid | output | 1 | Packet beat valid |
| m_tready | input | 1 | Sink ready |
| m_tdata | output | DATA_W | Packet beat data |
| m_tkeep | output | DATA_W/32 | One bit per Dword lane |
| m_tlast | output | 1 | Final beat of the packet |
| m_fbe | output | 4 | First-beat first byte enables |
| m_lbe | output | 4 | First-beat last byte enables |
| m_lane | output | 3 | First-beat payload starting lane |

## Verification
The hardest case to reach is a packet whose descriptor arrives before its payload. Here `m_tvalid` must stay low for an open-ended time and then run without a gap. The bench drives this by handing over the descriptor first and idling the payload input for several cycles while checking that nothing is emitted, then supplying the payload. A second hard case is an aligned offset at or above the lane count (offset 6 on four lanes), which has to wrap the starting lane. A third is a long packet run under a pseudo-random ready pattern after earlier packets, so that the buffer pointers wrap mid-packet while the outputs are held.

// File: rtl/reqfmt_pkg.sv
package reqfmt_pkg;
  typedef enum logic {
    MODE_PACKED  = 1'b0,
    MODE_ALIGNED = 1'b1
  } fmt_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_SEND = 2'd2
  } fmt_state_e;

  localparam int unsigned DESC_DW = 4;
  localparam int unsigned DW_BITS = 32;

  // Dwords spanned by whole descriptor beats for a given lane count
  function automatic int unsigned hdr_span(input int unsigned lanes);
    return ((DESC_DW + lanes - 1) / lanes) * lanes;
  endfunction
endpackage

// File: rtl/reqfmt_pbuf.sv
module reqfmt_pbuf #(
  parameter int unsigned LANES = 4,
  parameter int unsigned DEPTH = 64
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic [$clog2(LANES+1)-1:0]            wr_ndw,
  input  logic [LANES*32-1:0]                   wr_data,
  output logic                                  space_ok,
  output logic [$clog2(DEPTH):0]                level,
  input  logic                                  pop_en,
  input  logic [$clog2(DEPTH):0]                pop_n,
  input  logic [LANES-1:0][$clog2(DEPTH)-1:0]   rd_ofs,
  output logic [LANES-1:0][31:0]                rd_dw
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [31:0] mem [DEPTH];
  logic [AW:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [AW:0] free_n;

  assign level    = wptr_q - rptr_q;
  assign free_n   = (AW+1)'(DEPTH) - level;
  assign space_ok = free_n >= (AW+1)'(LANES);

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (wr_en)  wptr_d = wptr_q + (AW+1)'(wr_ndw);
    if (pop_en) rptr_d = rptr_q + pop_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
    end
  end

  // storage: no reset, written lane by lane from the write pointer
  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int w = 0; w < int'(LANES); w++) begin
        if (w < int'(wr_ndw))
          mem[AW'(wptr_q[AW-1:0] + AW'(w))] <= wr_data[32*w +: 32];
      end
    end
  end

  for (genvar j = 0; j < int'(LANES); j++) begin : g_rd
    assign rd_dw[j] = mem[AW'(rptr_q[AW-1:0] + rd_ofs[j])];
  end
endmodule

// File: rtl/reqfmt_ctrl.sv
module reqfmt_ctrl
  import reqfmt_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter int unsigned DEPTH = 64,
  parameter int unsigned PW    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         d_valid,
  output logic                         d_ready,
  input  logic                         d_mode,
  input  logic [2:0]                   d_aoff,
  input  logic [$clog2(DEPTH+1)-1:0]   d_len,
  input  logic [3:0]                   d_fbe,
  input  logic [3:0]                   d_lbe,
  input  logic [$clog2(DEPTH):0]       level,
  input  logic                         m_tready,
  output logic                         m_tvalid,
  output logic                         m_tlast,
  output logic [PW-1:0]                pos,
  output logic [PW-1:0]                fill,
  output logic [PW-1:0]                tot,
  output logic [3:0]                   m_fbe,
  output logic [3:0]                   m_lbe,
  output logic [2:0]                   m_lane,
  output logic                         pop_en,
  output logic [$clog2(DEPTH):0]       pop_n
);
  localparam int unsigned LENW = $clog2(DEPTH+1);
  localparam int unsigned SPAN = hdr_span(LANES);
  localparam logic [2:0]  LMSK = 3'(LANES-1);

  fmt_state_e      st_q, st_d;
  logic [LENW-1:0] len_q, len_d;
  logic [PW-1:0]   fill_q, fill_d, tot_q, tot_d, pos_q, pos_d;
  logic [3:0]      fbe_q, fbe_d, lbe_q, lbe_d;
  logic [2:0]      lane_q, lane_d;
  logic            first_beat, fin_beat, adv;

  assign first_beat = (pos_q == '0);
  assign fin_beat   = (pos_q + PW'(LANES)) >= tot_q;
  assign adv        = (st_q == ST_SEND) && m_tready;

  always_comb begin
    st_d   = st_q;
    len_d  = len_q;
    fill_d = fill_q;
    tot_d  = tot_q;
    pos_d  = pos_q;
    fbe_d  = fbe_q;
    lbe_d  = lbe_q;
    lane_d = lane_q;
    pop_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (d_valid) begin
          len_d  = d_len;
          fbe_d  = d_fbe;
          lbe_d  = d_lbe;
          if (fmt_mode_e'(d_mode) == MODE_ALIGNED) begin
            lane_d = d_aoff & LMSK;
            fill_d = PW'(SPAN - DESC_DW) + PW'(d_aoff & LMSK);
          end else begin
            lane_d = 3'd0;
            fill_d = '0;
          end
          tot_d = PW'(DESC_DW) + fill_d + PW'(d_len);
          pos_d = '0;
          st_d  = ST_FILL;
        end
      end
      ST_FILL: begin
        if ((LENW+1)'(level) >= (LENW+1)'(len_q)) st_d = ST_SEND;
      end
      ST_SEND: begin
        if (adv) begin
          if (fin_beat) begin
            pop_en = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            pos_d = pos_q + PW'(LANES);
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      len_q  <= '0;
      fill_q <= '0;
      tot_q  <= '0;
      pos_q  <= '0;
      fbe_q  <= '0;
      lbe_q  <= '0;
      lane_q <= '0;
    end else begin
      st_q   <= st_d;
      len_q  <= len_d;
      fill_q <= fill_d;
      tot_q  <= tot_d;
      pos_q  <= pos_d;
      fbe_q  <= fbe_d;
      lbe_q  <= lbe_d;
      lane_q <= lane_d;
    end
  end

  assign d_ready  = (st_q == ST_IDLE);
  assign m_tvalid = (st_q == ST_SEND);
  assign m_tlast  = m_tvalid && fin_beat;
  assign pos      = pos_q;
  assign fill     = fill_q;
  assign tot      = tot_q;
  assign pop_n    = ($clog2(DEPTH)+1)'(len_q);
  assign m_fbe    = (m_tvalid && first_beat) ? fbe_q  : 4'd0;
  assign m_lbe    = (m_tvalid && first_beat) ? lbe_q  : 4'd0;
  assign m_lane   = (m_tvalid && first_beat) ? lane_q : 3'd0;
endmodule

// File: rtl/reqfmt_lane.sv
module reqfmt_lane
  import reqfmt_pkg::*;
#(
  parameter int unsigned J     = 0,
  parameter int unsigned DEPTH = 64,
  parameter int unsigned PW    = 8
) (
  input  logic [PW-1:0]            pos,
  input  logic [PW-1:0]            fill,
  input  logic [PW-1:0]            tot,
  input  logic [127:0]             hdr,
  input  logic [31:0]              pay_dw,
  output logic [$clog2(DEPTH)-1:0] rd_ofs,
  output logic                     keep,
  output logic [31:0]              data
);
  localparam int unsigned AW = $clog2(DEPTH);
  logic [PW-1:0] p;

  assign p      = pos + PW'(J);
  assign keep   = p < tot;
  assign rd_ofs = AW'(p - PW'(DESC_DW) - fill);

  always_comb begin
    if (!keep)                           data = '0;
    else if (p < PW'(DESC_DW))           data = hdr[32*p[1:0] +: 32];
    else if (p < PW'(DESC_DW) + fill)    data = '0;
    else                                 data = pay_dw;
  end
endmodule

// File: rtl/reqpkt_fmt.sv
module reqpkt_fmt
  import reqfmt_pkg::*;
#(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned BUF_DW = 64
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              d_valid,
  output logic                              d_ready,
  input  logic [127:0]                      d_hdr,
  input  logic                              d_mode,
  input  logic [2:0]                        d_aoff,
  input  logic [$clog2(BUF_DW+1)-1:0]       d_len,
  input  logic [3:0]                        d_fbe,
  input  logic [3:0]                        d_lbe,
  input  logic                              p_valid,
  output logic                              p_ready,
  input  logic [DATA_W-1:0]                 p_data,
  input  logic [$clog2(DATA_W/32+1)-1:0]    p_ndw,
  output logic                              m_tvalid,
  input  logic                              m_tready,
  output logic [DATA_W-1:0]                 m_tdata,
  output logic [DATA_W/32-1:0]              m_tkeep,
  output logic                              m_tlast,
  output logic [3:0]                        m_fbe,
  output logic [3:0]                        m_lbe,
  output logic [2:0]                        m_lane
);
  localparam int unsigned LANES = DATA_W / 32;
  localparam int unsigned AW    = $clog2(BUF_DW);
  localparam int unsigned PW    = $clog2(BUF_DW + 2*LANES + 16) + 1;

  logic [AW:0]                level, pop_n;
  logic                       pop_en;
  logic [LANES-1:0][AW-1:0]   rd_ofs;
  logic [LANES-1:0][31:0]     rd_dw;
  logic [PW-1:0]              pos, fill, tot;
  logic [LANES-1:0]           keep_w;
  logic [DATA_W-1:0]          data_w;

  reqfmt_pbuf #(.LANES(LANES), .DEPTH(BUF_DW)) u_pbuf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(p_valid && p_ready), .wr_ndw(p_ndw), .wr_data(p_data),
    .space_ok(p_ready), .level(level),
    .pop_en(pop_en), .pop_n(pop_n),
    .rd_ofs(rd_ofs), .rd_dw(rd_dw)
  );

  reqfmt_ctrl #(.LANES(LANES), .DEPTH(BUF_DW), .PW(PW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .d_valid(d_valid), .d_ready(d_ready), .d_mode(d_mode), .d_aoff(d_aoff),
    .d_len(d_len), .d_fbe(d_fbe), .d_lbe(d_lbe),
    .level(level), .m_tready(m_tready),
    .m_tvalid(m_tvalid), .m_tlast(m_tlast),
    .pos(pos), .fill(fill), .tot(tot),
    .m_fbe(m_fbe), .m_lbe(m_lbe), .m_lane(m_lane),
    .pop_en(pop_en), .pop_n(pop_n)
  );

  for (genvar j = 0; j < int'(LANES); j++) begin : g_lane
    reqfmt_lane #(.J(j), .DEPTH(BUF_DW), .PW(PW)) u_lane (
      .pos(pos), .fill(fill), .tot(tot), .hdr(d_hdr_q_sel),
      .pay_dw(rd_dw[j]), .rd_ofs(rd_ofs[j]),
      .keep(keep_w[j]), .data(data_w[32*j +: 32])
    );
  end

  // descriptor words are held for the whole packet
  logic [127:0] d_hdr_q_sel;
  logic [127:0] hdr_q, hdr_d;

  always_comb begin
    hdr_d = hdr_q;
    if (d_valid && d_ready) hdr_d = d_hdr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hdr_q <= '0;
    else        hdr_q <= hdr_d;
  end

  assign d_hdr_q_sel = hdr_q;
  assign m_tkeep     = m_tvalid ? keep_w : '0;
  assign m_tdata     = m_tvalid ? data_w : '0;
endmodule

// File: rtl/reqfmt_chk.sv
module reqfmt_chk #(
  parameter int unsigned DATA_W = 128
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    d_ready,
  input logic                    m_tvalid,
  input logic                    m_tready,
  input logic [DATA_W-1:0]       m_tdata,
  input logic [DATA_W/32-1:0]    m_tkeep,
  input logic                    m_tlast,
  input logic [3:0]              m_fbe,
  input logic [3:0]              m_lbe,
  input logic [2:0]              m_lane
);
  localparam int unsigned LANES = DATA_W / 32;

  logic first_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   first_q <= 1'b1;
    else if (m_tvalid && m_tready) first_q <= m_tlast;
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tkeep)
      && $stable(m_tlast) && $stable({m_fbe, m_lbe, m_lane}));

  p_nodrop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !(m_tready && m_tlast) |=> m_tvalid);

  p_keepfull_r6: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tlast |-> &m_tkeep);

  p_keepcont_r6: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> m_tkeep[0] && ((LANES'(m_tkeep + LANES'(1)) & m_tkeep) == '0));

  p_sbquiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !first_q |-> m_fbe == 4'd0 && m_lbe == 4'd0 && m_lane == 3'd0);

  p_lanerange_r4: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> m_lane <= 3'(LANES - 1));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    d_ready |-> !m_tvalid);
endmodule

bind reqpkt_fmt reqfmt_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_reqpkt_fmt.sv
module sim_reqpkt_fmt;
  localparam int DATA_W = 128;
  localparam int BUF_DW = 64;
  localparam int LANES  = DATA_W / 32;
  localparam int SPAN   = ((4 + LANES - 1) / LANES) * LANES;

  logic clk, rst_n;
  logic d_valid, d_ready, d_mode;
  logic [127:0] d_hdr;
  logic [2:0] d_aoff;
  logic [$clog2(BUF_DW+1)-1:0] d_len;
  logic [3:0] d_fbe, d_lbe;
  logic p_valid, p_ready;
  logic [DATA_W-1:0] p_data;
  logic [$clog2(LANES+1)-1:0] p_ndw;
  logic m_tvalid, m_tready, m_tlast;
  logic [DATA_W-1:0] m_tdata;
  logic [LANES-1:0] m_tkeep;
  logic [3:0] m_fbe, m_lbe;
  logic [2:0] m_lane;

  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_dw [256];
  logic [15:0] lfsr = 16'hACE1;

  reqpkt_fmt #(.DATA_W(DATA_W), .BUF_DW(BUF_DW)) u0 (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_payload(input int len, input logic [31:0] seed);
    int sent = 0;
    while (sent < len) begin
      int n = (len - sent > LANES) ? LANES : len - sent;
      @(negedge clk);
      p_valid = 1'b1;
      p_ndw   = ($clog2(LANES+1))'(n);
      p_data  = '1;
      for (int w = 0; w < n; w++) p_data[32*w +: 32] = seed + 32'(sent + w);
      while (!p_ready) @(negedge clk);
      sent += n;
    end
    @(negedge clk);
    p_valid = 1'b0;
  endtask

  task automatic send_desc(input bit mode, input int aoff, input int len,
                           input logic [3:0] fbe, input logic [3:0] lbe,
                           input logic [31:0] hseed);
    @(negedge clk);
    d_valid = 1'b1;
    d_mode  = mode;
    d_aoff  = 3'(aoff);
    d_len   = ($clog2(BUF_DW+1))'(len);
    d_fbe   = fbe;
    d_lbe   = lbe;
    for (int i = 0; i < 4; i++) d_hdr[32*i +: 32] = hseed + 32'(i);
    while (!d_ready) @(negedge clk);
    @(negedge clk);
    d_valid = 1'b0;
    d_hdr   = '0;
  endtask

  // builds the expected Dword layout from R2, R3, R4 and returns the total
  function automatic int build_exp(input bit mode, input int aoff, input int len,
                                   input logic [31:0] hseed, input logic [31:0] pseed);
    int fill = mode ? (SPAN - 4) + (aoff % LANES) : 0;
    for (int i = 0; i < 4; i++) exp_dw[i] = hseed + 32'(i);
    for (int i = 0; i < fill; i++) exp_dw[4+i] = '0;
    for (int i = 0; i < len; i++) exp_dw[4+fill+i] = pseed + 32'(i);
    return 4 + fill + len;
  endfunction

  task automatic collect(input string tag, input int tot, input bit bp,
                         input logic [3:0] fbe, input logic [3:0] lbe,
                         input logic [2:0] lane);
    int beat = 0, guard = 0;
    bit started = 0, done = 0, pv = 0, pr = 0;
    logic [DATA_W-1:0] sd; logic [LANES-1:0] sk; logic sl; logic [10:0] ss;
    while (!done && guard < 400) begin
      @(negedge clk);
      guard++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (pv && !pr) begin
        chk(m_tvalid && m_tdata == sd && m_tkeep == sk && m_tlast == sl &&
            {m_fbe, m_lbe, m_lane} == ss, "R7", {tag, " hold"},
            64'(m_tdata), 64'(sd));
      end else if (m_tvalid) begin
        started = 1;
        for (int j = 0; j < LANES; j++) begin
          int p = beat * LANES + j;
          bit ek = p < tot;
          chk(m_tkeep[j] == ek, "R6", {tag, " keep"}, 64'(m_tkeep[j]), 64'(ek));
          if (ek) chk(m_tdata[32*j +: 32] == exp_dw[p], p < 4 ? "R2" : "R4",
                      {tag, " data"}, 64'(m_tdata[32*j +: 32]), 64'(exp_dw[p]));
        end
        chk(m_tlast == ((beat + 1) * LANES >= tot), "R6", {tag, " last"},
            64'(m_tlast), 64'((beat + 1) * LANES >= tot));
        if (beat == 0)
          chk({m_fbe, m_lbe, m_lane} == {fbe, lbe, lane}, "R5", {tag, " sideband"},
              64'({m_fbe, m_lbe, m_lane}), 64'({fbe, lbe, lane}));
        else
          chk({m_fbe, m_lbe, m_lane} == 11'd0, "R5", {tag, " sideband later"},
              64'({m_fbe, m_lbe, m_lane}), 64'(0));
        chk(!d_ready, "R10", {tag, " busy"}, 64'(d_ready), 64'(0));
      end else if (started) begin
        chk(1'b0, "R8", {tag, " valid dropped"}, 64'(0), 64'(1));
      end
      m_tready = bp ? lfsr[0] : 1'b1;
      pv = m_tvalid; pr = m_tready;
      sd = m_tdata; sk = m_tkeep; sl = m_tlast; ss = {m_fbe, m_lbe, m_lane};
      if (m_tvalid && m_tready) begin
        if (m_tlast) done = 1;
        beat++;
      end
    end
    chk(done, "R8", {tag, " completed"}, 64'(done), 64'(1));
    @(negedge clk);
    m_tready = 1'b0;
    chk(d_ready && !m_tvalid, "R10", {tag, " idle again"}, 64'(d_ready), 64'(1));
  endtask

  task automatic run_pkt(input string tag, input bit mode, input int aoff, input int len,
                         input logic [3:0] fbe, input logic [3:0] lbe, input bit bp,
                         input bit late, input logic [31:0] seed);
    int tot = build_exp(mode, aoff, len, seed ^ 32'h0D00_0000, seed);
    logic [2:0] lane = mode ? 3'(aoff % LANES) : 3'd0;
    if (!late) push_payload(len, seed);
    send_desc(mode, aoff, len, fbe, lbe, seed ^ 32'h0D00_0000);
    if (late) begin
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        chk(!m_tvalid, "R8", {tag, " wait for payload"}, 64'(m_tvalid), 64'(0));
      end
      push_payload(len, seed);
    end
    collect(tag, tot, bp, fbe, lbe, lane);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; d_valid = 0; d_hdr = '0; d_mode = 0; d_aoff = 0; d_len = '0;
    d_fbe = 0; d_lbe = 0; p_valid = 0; p_data = '0; p_ndw = '0; m_tready = 0;
    repeat (3) @(negedge clk);
    chk(!m_tvalid, "R1", "valid in reset", 64'(m_tvalid), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(!m_tvalid && d_ready, "R1", "desc ready after reset", 64'(d_ready), 64'(1));
    chk(p_ready, "R9", "payload ready after reset", 64'(p_ready), 64'(1));
  endtask

  // R3: packed layout, R2 header placement
  task automatic t_packed();
    run_pkt("packed_len5", 1'b0, 5, 5, 4'hF, 4'h3, 1'b0, 1'b0, 32'hA100_0000);
  endtask

  // R4: aligned layout with filler, R7 under backpressure
  task automatic t_aligned();
    run_pkt("aligned_off3", 1'b1, 3, 6, 4'hE, 4'h7, 1'b1, 1'b0, 32'hA200_0000);
  endtask

  // R4: offset beyond lane count wraps modulo LANES
  task automatic t_aligned_wrap();
    run_pkt("aligned_off6", 1'b1, 6, 9, 4'h6, 4'hC, 1'b1, 1'b0, 32'hA300_0000);
  endtask

  // R8: descriptor before payload, single Dword
  task automatic t_late();
    run_pkt("late_len1", 1'b1, 1, 1, 4'h9, 4'h0, 1'b0, 1'b1, 32'hA400_0000);
  endtask

  // R9: long packets wrap the buffer pointers under random ready
  task automatic t_long();
    run_pkt("packed_len20", 1'b0, 0, 20, 4'hF, 4'hF, 1'b1, 1'b0, 32'hA500_0000);
    run_pkt("aligned_len40", 1'b1, 2, 40, 4'h8, 4'h1, 1'b1, 1'b0, 32'hA600_0000);
  endtask

  initial begin
    t_reset();
    t_packed();
    t_aligned();
    t_aligned_wrap();
    t_late();
    t_long();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule